// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Half-Line Rejection

This block receives a composite sync stream that has already been sliced to one bit (active low) and rebuilds from it a clean horizontal sync. Each falling edge that the block accepts starts an active-low output pulse of fixed length. After an accepted edge, the block ignores further falling edges until about 70% of the measured line period has passed. This removes the equalising and serration pulses that occur at twice the line rate, as well as copy-protection pulses that follow the real sync.

The block measures the spacing between accepted edges and uses it to track the line period. It starts from a default period and raises a lock flag once the spacing is consistent. If no edge is accepted for two estimated line periods, it declares loss of sync. While sync is lost, the horizontal output stays high.

Top module: `hsync_regen`

## Requirements
- R1: Each accepted falling edge of `csync_n_i` drives `hsync_n_o` low for exactly `PULSE_W` clock cycles. The output goes low on the (`SYNC_STAGES`+1)-th rising clock edge after the input falls; the input is synchronised through `SYNC_STAGES` flip-flops.
- R2: While reset is held, and directly after it, `hsync_n_o` is 1, `valid_o` is 0 and `period_o` equals `LINE_DEF`.
- R3: Outside the search state, a falling edge that arrives D cycles after the previous accepted edge is accepted if and only if D >= floor(E*179/256), where E is the current estimate on `period_o`.
- R4: A falling edge rejected by the R3 window produces no output pulse, leaves `valid_o` unchanged and does not disturb the estimate. The next real edge measures its interval from the last accepted edge.
- R5: While locked, an accepted edge whose interval I satisfies E <= 2*I <= 3*E replaces the estimate with I. Any other interval leaves the estimate unchanged and keeps the lock.
- R6: In the search state (after reset or after loss), the first falling edge is accepted regardless of its timing. It produces a pulse and moves the block to acquisition, with `valid_o` still 0.
- R7: During acquisition, every accepted edge loads its interval into the estimate. `valid_o` rises only when that interval satisfies the R5 window against the estimate held before the update.
- R8: If no edge is accepted for 2*E cycles after the last accepted edge, `valid_o` falls to 0 on that cycle. The estimate is kept, and `hsync_n_o` stays high until a new edge arrives.
- R9: After loss, one accepted edge does not restore `valid_o`. A second edge at a consistent interval does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n_i | input | 1 | Sliced composite sync, active low, asynchronous to `clk` |
| hsync_n_o | output | 1 | Regenerated horizontal sync, active low |
| valid_o | output | 1 | High while the line timing is locked |
| period_o | output | CNT_W | Current line-period estimate, in clock cycles |

## Verification
The bench builds the block with a 100-cycle default line, 10-cycle pulses, a 12-bit counter and two synchroniser stages. At these sizes the inhibit threshold lands at 69 cycles, so every offset of a spurious edge around it can be swept. The same sizes allow every locked interval from just below to just above the 150% bound (and up to the loss limit) to be swept, and acquisition periods from 70 to 195 cycles to be stepped through. Loss, relock and the exact cycle of the output fall are reached in a few hundred cycles, and each expected value comes from the integer formulas in the requirements.

// File: rtl/hsr_pkg.sv
`timescale 1ns/1ps
package hsr_pkg;

    // tracker state
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_ACQ    = 2'd1,
        ST_LOCK   = 2'd2
    } trk_state_e;

    // inhibit fraction = INH_NUM / 2**INH_SHIFT (about 0.70)
    localparam int unsigned INH_NUM   = 179;
    localparam int unsigned INH_SHIFT = 8;

    // per-cycle tracker decision, shared by the tracker and the top
    typedef struct packed {
        logic accept;
        logic timeout;
        logic consistent;
    } trk_dec_t;

    function automatic logic [31:0] inhibit_len(input logic [31:0] est);
        logic [39:0] prod;
        prod = {8'd0, est} * 40'(INH_NUM);
        return prod[INH_SHIFT +: 32];
    endfunction

    function automatic logic interval_ok(input logic [31:0] ivl, input logic [31:0] est);
        logic [33:0] twice;
        logic [33:0] lo;
        logic [33:0] hi;
        twice = {1'b0, ivl, 1'b0};
        lo    = {2'b00, est};
        hi    = {2'b00, est} + {1'b0, est, 1'b0};
        return (twice >= lo) && (twice <= hi);
    endfunction

endpackage

// File: rtl/hsr_sync_edge.sv
`timescale 1ns/1ps
module hsr_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q[0] <= sync_n_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/hsr_line_tracker.sv
`timescale 1ns/1ps
module hsr_line_tracker
    import hsr_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned LINE_DEF = 12720
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    output trk_dec_t         dec_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] EST_INIT = CNT_W'(LINE_DEF);

    trk_state_e       state_q;
    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] est_q;
    logic [31:0]      inh_w;
    logic             open_w;

    always_comb begin
        inh_w            = inhibit_len(32'(est_q));
        open_w           = (32'(since_q) >= inh_w);
        dec_o.consistent = interval_ok(32'(since_q), 32'(est_q));
        dec_o.timeout    = ({1'b0, since_q} >= {est_q, 1'b0});
        dec_o.accept     = fall_i && ((state_q == ST_SEARCH) || open_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEARCH;
            since_q <= '0;
            est_q   <= EST_INIT;
        end else if (dec_o.accept) begin
            since_q <= CNT_W'(1);
            unique case (state_q)
                ST_SEARCH: state_q <= ST_ACQ;
                ST_ACQ: begin
                    est_q <= since_q;
                    if (dec_o.consistent) begin
                        state_q <= ST_LOCK;
                    end
                end
                ST_LOCK: begin
                    if (dec_o.consistent) begin
                        est_q <= since_q;
                    end
                end
                default: state_q <= ST_SEARCH;
            endcase
        end else begin
            if (since_q != CNT_MAX) begin
                since_q <= since_q + CNT_W'(1);
            end
            if (dec_o.timeout && (state_q != ST_SEARCH)) begin
                state_q <= ST_SEARCH;
            end
        end
    end

    assign valid_o  = (state_q == ST_LOCK);
    assign period_o = est_q;

endmodule

// File: rtl/hsr_pulse_gen.sv
`timescale 1ns/1ps
module hsr_pulse_gen #(
    parameter int unsigned PULSE_W = 1040
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_n_o
);
    localparam int unsigned PW_W = $clog2(PULSE_W + 1);

    logic [PW_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trig_i) begin
            left_q <= PW_W'(PULSE_W);
        end else if (left_q != '0) begin
            left_q <= left_q - PW_W'(1);
        end
    end

    assign pulse_n_o = (left_q == '0);

endmodule

// File: rtl/hsync_regen.sv
`timescale 1ns/1ps
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned LINE_DEF    = 12720,
    parameter int unsigned PULSE_W     = 1040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csync_n_i,
    output logic             hsync_n_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o
);
    logic     fall_w;
    trk_dec_t dec_w;

    hsr_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) edge_i (
        .clk      (clk),
        .rst      (rst),
        .sync_n_i (csync_n_i),
        .fall_o   (fall_w)
    );

    hsr_line_tracker #(
        .CNT_W    (CNT_W),
        .LINE_DEF (LINE_DEF)
    ) trk_i (
        .clk      (clk),
        .rst      (rst),
        .fall_i   (fall_w),
        .dec_o    (dec_w),
        .valid_o  (valid_o),
        .period_o (period_o)
    );

    hsr_pulse_gen #(
        .PULSE_W(PULSE_W)
    ) pulse_i (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (dec_w.accept),
        .pulse_n_o (hsync_n_o)
    );

endmodule

// File: rtl/hsync_regen_chk.sv
`timescale 1ns/1ps
module hsync_regen_chk
    import hsr_pkg::*;
#(
    parameter int unsigned PULSE_W = 1040,
    parameter int unsigned CNT_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             hsync_n_o,
    input logic             valid_o,
    input logic [CNT_W-1:0] period_o
);
    logic             h_q;
    logic             val_q;
    logic [CNT_W-1:0] per_q;
    logic [31:0]      gap_q;
    logic [31:0]      low_q;
    logic [CNT_W+1:0] per2_w;
    logic [CNT_W+1:0] old_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q   <= 1'b1;
            val_q <= 1'b0;
            per_q <= '0;
            gap_q <= '0;
            low_q <= '0;
        end else begin
            h_q   <= hsync_n_o;
            val_q <= valid_o;
            per_q <= period_o;
            if (h_q && !hsync_n_o) begin
                gap_q <= 32'd1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 32'd1;
            end
            low_q <= hsync_n_o ? 32'd0 : low_q + 32'd1;
        end
    end

    assign per2_w = {1'b0, period_o, 1'b0};
    assign old_w  = {2'b00, per_q};

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!h_q && hsync_n_o) |-> (low_q == 32'(PULSE_W)));

    // R2
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hsync_n_o && !valid_o));

    // R3
    inhibit_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_q && !hsync_n_o && val_q) |-> (gap_q >= inhibit_len(32'(per_q))));

    // R5
    est_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((period_o != per_q) && val_q) |-> ((per2_w >= old_w) && (per2_w <= old_w + {old_w[CNT_W:0], 1'b0})));

    // R8
    loss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_o) |-> (hsync_n_o && $stable(period_o)));

endmodule

bind hsync_regen hsync_regen_chk #(
    .PULSE_W (PULSE_W),
    .CNT_W   (CNT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .hsync_n_o (hsync_n_o),
    .valid_o   (valid_o),
    .period_o  (period_o)
);

// File: tb/hsync_regen_tb_top.sv
`timescale 1ns/1ps
module hsync_regen_tb_top;
    localparam int SYNC = 2;
    localparam int LINE = 100;
    localparam int PW   = 10;
    localparam int CW   = 12;
    localparam int LOW  = 5;

    logic          clk     = 1'b0;
    logic          rst     = 1'b1;
    logic          csync_n = 1'b1;
    logic          hsync_n;
    logic          valid;
    logic [CW-1:0] period;

    int checks  = 0;
    int errors  = 0;
    int pulses  = 0;
    int low_cnt = 0;
    logic h_prev = 1'b1;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    hsync_regen #(
        .SYNC_STAGES (SYNC),
        .CNT_W       (CW),
        .LINE_DEF    (LINE),
        .PULSE_W     (PW)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .csync_n_i (csync_n),
        .hsync_n_o (hsync_n),
        .valid_o   (valid),
        .period_o  (period)
    );

    function automatic int inh(int e);
        return (e * 179) / 256;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // pulse counter and width monitor (R1)
    always @(negedge clk) begin
        if (rst) begin
            low_cnt = 0;
        end else begin
            if (h_prev && !hsync_n) pulses++;
            if (!hsync_n) begin
                low_cnt++;
            end else if (!h_prev) begin
                chk(low_cnt == PW, "R1 pulse width", low_cnt, PW);
                low_cnt = 0;
            end
        end
        h_prev = hsync_n;
    end

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        csync_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one falling edge, then wait gap cycles from that edge
    task automatic line(int gap);
        csync_n = 1'b0;
        repeat (LOW) @(negedge clk);
        csync_n = 1'b1;
        repeat (gap - LOW) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int p;
        do_reset();

        // R2 reset state
        chk(hsync_n == 1'b1, "R2 hsync idle", int'(hsync_n), 1);
        chk(valid == 1'b0, "R2 valid low", int'(valid), 0);
        chk(int'(period) == LINE, "R2 default period", int'(period), LINE);

        // R1 latency, R6 first edge in search
        csync_n = 1'b0;
        repeat (SYNC) @(negedge clk);
        chk(hsync_n == 1'b1, "R1 before latency", int'(hsync_n), 1);
        @(negedge clk);
        chk(hsync_n == 1'b0, "R1 at latency", int'(hsync_n), 0);
        repeat (LOW - SYNC - 1) @(negedge clk);
        csync_n = 1'b1;
        repeat (LINE - LOW) @(negedge clk);
        chk(valid == 1'b0, "R6 one edge no lock", int'(valid), 0);
        chk(pulses == 1, "R6 first edge pulse", pulses, 1);

        // R7 lock on consistent second edge
        line(LINE);
        chk(valid == 1'b1, "R7 lock", int'(valid), 1);
        chk(int'(period) == LINE, "R7 period", int'(period), LINE);

        // R8 loss after 2*E silent cycles
        repeat (102) @(negedge clk);
        chk(valid == 1'b1, "R8 still locked", int'(valid), 1);
        @(negedge clk);
        chk(valid == 1'b0, "R8 loss", int'(valid), 0);
        chk(int'(period) == LINE, "R8 estimate kept", int'(period), LINE);
        p = pulses;
        repeat (300) @(negedge clk);
        chk(pulses == p, "R8 no pulses", pulses - p, 0);
        chk(hsync_n == 1'b1, "R8 held high", int'(hsync_n), 1);

        // R9 relock
        line(LINE);
        chk(valid == 1'b0, "R9 one edge", int'(valid), 0);
        line(LINE);
        chk(valid == 1'b1, "R9 relocked", int'(valid), 1);

        // R7 inconsistent interval adopted in acquisition
        do_reset();
        line(170);
        line(170);
        chk(valid == 1'b0, "R7 adopt no lock", int'(valid), 0);
        chk(int'(period) == 170, "R7 adopt period", int'(period), 170);
        line(20);
        chk(valid == 1'b1, "R7 adopt lock", int'(valid), 1);
        chk(int'(period) == 170, "R7 adopt final", int'(period), 170);

        // R7 acquisition sweep over line periods
        for (int lp = 70; lp <= 195; lp += 5) begin
            do_reset();
            line(lp);
            line(lp);
            chk(valid == ((2 * lp <= 3 * LINE) ? 1'b1 : 1'b0), "R7 sweep second edge",
                int'(valid), (2 * lp <= 3 * LINE) ? 1 : 0);
            line(lp);
            chk(valid == 1'b1, "R7 sweep lock", int'(valid), 1);
            chk(int'(period) == lp, "R7 sweep period", int'(period), lp);
        end

        // R5 locked interval window sweep
        for (int g = 140; g <= 199; g++) begin
            int exp_p;
            do_reset();
            line(LINE);
            line(LINE);
            line(g);
            line(20);
            exp_p = (2 * g <= 3 * LINE) ? g : LINE;
            chk(int'(period) == exp_p, "R5 window", int'(period), exp_p);
            chk(valid == 1'b1, "R5 lock kept", int'(valid), 1);
        end

        // R3 / R4 inhibit sweep with a spurious edge at offset d
        for (int d = 55; d <= 85; d++) begin
            int acc;
            int exp_p;
            do_reset();
            repeat (3) line(LINE);
            line(d);
            p = pulses;
            line(LINE - d);
            acc = (d >= inh(LINE)) ? 1 : 0;
            chk((pulses - p) == acc, "R3 spurious edge pulse", pulses - p, acc);
            chk(valid == 1'b1, "R4 valid unchanged", int'(valid), 1);
            line(20);
            exp_p = (acc == 1) ? d : LINE;
            chk(int'(period) == exp_p, "R4 period after spurious", int'(period), exp_p);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule